// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Controller

This block generates the service requests for one channel of an asynchronous serial port. A 32-bit control word is written and read over a simple register bus. The control word decides how each FIFO direction is serviced: either by DMA request lines, or by the shared interrupt. It also decides which receive error flags may interrupt the processor, and which transitions of the clear-to-send pin are recorded.

The FIFOs, the receiver and the other status registers lie outside this block. Their state comes in as level flags: free space in the transmit FIFO, receive data full, receive timeout, and the frame, parity and overrun errors. The clear-to-send pin passes through a two-flop synchroniser. An edge that matches the selected condition sets a sticky status bit. Software clears that bit by pulsing a write-one-to-clear strobe. All enabled sources are ORed into one level-sensitive interrupt output.

Top module: `sio_req_ctrl`

## Requirements
- R1: After reset the control word reads 0, and irq, dma_tx_req, dma_rx_req and cts_stat are all 0, whatever the status flags are.
- R2: A write stores only bits 15:9 of the write data. Read data returns those seven bits in place, and returns 0 in bits 31:16 and 8:0. Writes to the zero bits have no effect.
- R3: dma_tx_req is high exactly while control bit 15 (transmit DMA on) is 1 and tx_space is 1.
- R4: dma_rx_req is high exactly while control bit 14 (receive DMA on) is 1 and at least one of rx_full and rx_timeout is 1.
- R5: While control bit 13 is 1, irq is high whenever tx_space is 1.
- R6: While control bit 12 is 1, irq is high whenever rx_full or rx_timeout is 1.
- R7: While control bit 11 is 1, irq is high whenever err_frame, err_parity or err_overrun is 1.
- R8: Control bits 10:9 select the CTS edge that is recorded: 00 records none, 01 records rising, 10 records falling, 11 records both. After the pin changes at a matching edge, cts_stat goes to 1 at the third rising clock edge. While cts_stat is 1, irq is high.
- R9: cts_stat is sticky. A one-cycle cts_clr pulse clears it. When a matching edge is detected in the same cycle as the clear, cts_stat stays 1.
- R10: The DMA enables do not drive irq. With no interrupt enable set and cts_stat at 0, irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| cts_clr | input | 1 | Write-one-to-clear strobe for cts_stat |
| tx_space | input | 1 | Transmit FIFO has free space |
| rx_full | input | 1 | Receive data full |
| rx_timeout | input | 1 | Receive timeout |
| err_frame | input | 1 | Frame error flag |
| err_parity | input | 1 | Parity error flag |
| err_overrun | input | 1 | Overrun error flag |
| cts_stat | output | 1 | Sticky CTS edge status |
| irq | output | 1 | Level interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
Each status flag is raised alone under its own enable. This tests each OR term of the interrupt and of the DMA requests separately, and shows that a DMA enable never reaches the interrupt. Write patterns of all ones, all zeros and a mixed value tell the stored field bits apart from the reserved bits. For CTS, a rising edge and a falling edge are applied under each of the four condition codes, and the status is sampled one cycle before and at the expected latching edge. This exposes a wrong decode and also a wrong synchroniser depth. A clear applied in the same cycle as a detected edge shows whether the set takes priority over the clear.

// File: rtl/sio_req_ctrl.sv
module sio_req_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        cts_pin,
  input  logic        cts_clr,
  input  logic        tx_space,
  input  logic        rx_full,
  input  logic        rx_timeout,
  input  logic        err_frame,
  input  logic        err_parity,
  input  logic        err_overrun,
  output logic        cts_stat,
  output logic        irq,
  output logic        dma_tx_req,
  output logic        dma_rx_req
);

  localparam logic [31:0] WMASK = 32'h0000_FE00;

  logic       tx_dma_on, rx_dma_on, tx_irq_on, rx_irq_on, err_irq_on;
  logic [1:0] cts_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dma_on  <= 1'b0;
      rx_dma_on  <= 1'b0;
      tx_irq_on  <= 1'b0;
      rx_irq_on  <= 1'b0;
      err_irq_on <= 1'b0;
      cts_mode   <= 2'b00;
    end else if (wr_en) begin
      tx_dma_on  <= wr_data[15];
      rx_dma_on  <= wr_data[14];
      tx_irq_on  <= wr_data[13];
      rx_irq_on  <= wr_data[12];
      err_irq_on <= wr_data[11];
      cts_mode   <= wr_data[10:9];
    end
  end

  assign rd_data = {16'h0000, tx_dma_on, rx_dma_on, tx_irq_on, rx_irq_on,
                    err_irq_on, cts_mode, 9'h000};

  logic [SYNC_STAGES-1:0] cts_sync;
  logic                   cts_prev;
  logic                   cts_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_sync <= '0;
      cts_prev <= 1'b0;
    end else begin
      cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_pin};
      cts_prev <= cts_now;
    end
  end

  assign cts_now = cts_sync[SYNC_STAGES-1];

  logic cts_rise, cts_fall, cts_hit;
  assign cts_rise = cts_now & ~cts_prev;
  assign cts_fall = ~cts_now & cts_prev;
  assign cts_hit  = (cts_mode[0] & cts_rise) | (cts_mode[1] & cts_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cts_stat <= 1'b0;
    else if (cts_hit) cts_stat <= 1'b1;
    else if (cts_clr) cts_stat <= 1'b0;
  end

  logic rx_ready, rx_err;
  assign rx_ready = rx_full | rx_timeout;
  assign rx_err   = err_frame | err_parity | err_overrun;

  assign dma_tx_req = tx_dma_on & tx_space;
  assign dma_rx_req = rx_dma_on & rx_ready;
  assign irq = (tx_irq_on & tx_space) | (rx_irq_on & rx_ready) |
               (err_irq_on & rx_err) | cts_stat;

  assert_rd_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & WMASK));

  assert_txdma_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_space |-> !dma_tx_req);

  assert_rxdma_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_full && !rx_timeout) |-> !dma_rx_req);

  assert_cts_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_mode == 2'b00 && !cts_stat) |=> !cts_stat);

  assert_cts_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cts_stat |-> irq);

  assert_cts_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_stat && !cts_clr) |=> cts_stat);

  assert_cts_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_clr && cts_hit) |=> cts_stat);

  assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[13:11] == 3'b000 && !cts_stat) |-> !irq);

endmodule

// File: tb/sio_req_ctrl_tb_top.sv
module sio_req_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, wr_en, cts_pin, cts_clr;
  logic        tx_space, rx_full, rx_timeout, err_frame, err_parity, err_overrun;
  logic [31:0] wr_data, rd_data;
  logic        cts_stat, irq, dma_tx_req, dma_rx_req;

  sio_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cts_pin(cts_pin), .cts_clr(cts_clr), .tx_space(tx_space), .rx_full(rx_full),
    .rx_timeout(rx_timeout), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .cts_stat(cts_stat), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); cts_clr = 1'b1;
    @(negedge clk); cts_clr = 1'b0;
  endtask

  task automatic flags(input logic [5:0] f);
    {tx_space, rx_full, rx_timeout, err_frame, err_parity, err_overrun} = f;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 32'h0);
    flags(6'b111111);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 dma_tx_req", {31'b0, dma_tx_req}, 0);
    chk("R1 dma_rx_req", {31'b0, dma_rx_req}, 0);
    chk("R1 cts_stat", {31'b0, cts_stat}, 0);
    flags(6'b0);
  endtask

  task automatic t_regs();
    wr(32'hFFFF_FFFF); chk("R2 all ones", rd_data, 32'h0000_FE00);
    wr(32'h0000_0000); chk("R2 zero", rd_data, 32'h0);
    wr(32'h5A5A_A5FF); chk("R2 mixed", rd_data, 32'h0000_A400);
    wr(32'h0);
  endtask

  task automatic t_dma();
    wr(32'h0000_8000);
    flags(6'b000000); chk("R3 tx no space", {31'b0, dma_tx_req}, 0);
    flags(6'b100000); chk("R3 tx space", {31'b0, dma_tx_req}, 1);
    chk("R10 dma not irq", {31'b0, irq}, 0);
    wr(32'h0000_4000);
    chk("R3 tx disabled", {31'b0, dma_tx_req}, 0);
    flags(6'b010000); chk("R4 rx full", {31'b0, dma_rx_req}, 1);
    flags(6'b001000); chk("R4 rx timeout", {31'b0, dma_rx_req}, 1);
    flags(6'b000111); chk("R4 rx idle", {31'b0, dma_rx_req}, 0);
    chk("R10 quiet irq", {31'b0, irq}, 0);
    flags(6'b0); wr(32'h0);
  endtask

  task automatic t_irq();
    wr(32'h0000_2000);
    flags(6'b100000); chk("R5 tx space irq", {31'b0, irq}, 1);
    flags(6'b011111); chk("R5 other flags", {31'b0, irq}, 0);
    wr(32'h0000_1000);
    flags(6'b010000); chk("R6 rx full irq", {31'b0, irq}, 1);
    flags(6'b001000); chk("R6 timeout irq", {31'b0, irq}, 1);
    flags(6'b100111); chk("R6 other flags", {31'b0, irq}, 0);
    wr(32'h0000_0800);
    flags(6'b000100); chk("R7 frame irq", {31'b0, irq}, 1);
    flags(6'b000010); chk("R7 parity irq", {31'b0, irq}, 1);
    flags(6'b000001); chk("R7 overrun irq", {31'b0, irq}, 1);
    flags(6'b111000); chk("R7 other flags", {31'b0, irq}, 0);
    flags(6'b0); wr(32'h0);
  endtask

  task automatic t_cts();
    for (int m = 0; m < 4; m++) begin
      wr(32'(m) << 9);
      clr_pulse();
      @(negedge clk); cts_pin = 1'b1;
      repeat (2) @(negedge clk);
      chk($sformatf("R8 mode %0d rise early", m), {31'b0, cts_stat}, 0);
      @(negedge clk);
      chk($sformatf("R8 mode %0d rise", m), {31'b0, cts_stat}, 32'(m & 1));
      chk($sformatf("R8 mode %0d rise irq", m), {31'b0, irq}, 32'(m & 1));
      repeat (2) @(negedge clk);
      clr_pulse();
      chk($sformatf("R9 mode %0d cleared", m), {31'b0, cts_stat}, 0);
      @(negedge clk); cts_pin = 1'b0;
      repeat (3) @(negedge clk);
      chk($sformatf("R8 mode %0d fall", m), {31'b0, cts_stat}, 32'((m >> 1) & 1));
      repeat (2) @(negedge clk);
      clr_pulse();
    end
  endtask

  task automatic t_sticky();
    wr(32'h0000_0600);
    @(negedge clk); cts_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 set", {31'b0, cts_stat}, 1);
    repeat (6) @(negedge clk);
    chk("R9 sticky", {31'b0, cts_stat}, 1);
    @(negedge clk); cts_pin = 1'b0;
    repeat (2) @(negedge clk);
    cts_clr = 1'b1;
    @(negedge clk); cts_clr = 1'b0;
    chk("R9 edge wins over clear", {31'b0, cts_stat}, 1);
    repeat (2) @(negedge clk);
    clr_pulse();
    chk("R9 clear", {31'b0, cts_stat}, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cts_pin = 1'b0; cts_clr = 1'b0;
    tx_space = 1'b0; rx_full = 1'b0; rx_timeout = 1'b0;
    err_frame = 1'b0; err_parity = 1'b0; err_overrun = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_dma();
    t_irq();
    t_cts();
    t_sticky();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule